// File: doc/BRIEF.md
# FIFO-Level Interrupt Bid Former

This block produces the interrupt bids for one serial channel. It makes one bid for the receiver and one for the transmitter, and both go to a shared interrupt arbiter. Each bid is a 10-bit word. The FIFO level sits in the most significant field, so a receiver that is filling up or a transmitter that is draining outranks one with little pending work. Below the level field come a programmable priority, the channel number and a source tag.

A 2-bit start-level field per direction sets when a source begins to bid. A per-source enable bit gates the bid. A source that is not bidding drives an all-zero word and a low valid flag. The logic is purely combinational. The FIFOs, the other event sources and the arbitration across channels all sit outside this block.

Top module: `fifo_irq_bid`

## Requirements
- R1: When `rx_valid` is high, `rx_bid` holds `rx_count` in bits [9:5], `prio` in bits [4:3], `chan` in bits [2:1], and 1 in bit 0.
- R2: When `tx_valid` is high, `tx_bid` holds `tx_space` in bits [9:5], `prio` in bits [4:3], `chan` in bits [2:1], and 0 in bit 0.
- R3: The receiver is active when `rx_count` is at least the start level chosen by `rx_level`. The codes are 00 = 1 entry, 01 = 8 entries, 10 = 12 entries and 11 = 16 entries. A count of zero never bids.
- R4: The transmitter is active when `tx_space` is at least the start level chosen by `tx_level`. The codes are 00 = 1 free slot, 01 = 8 free slots, 10 = 12 free slots and 11 = 16 free slots. Zero free space never bids.
- R5: While `rx_en` is low, `rx_valid` stays low whatever the receiver's level. While `tx_en` is low, `tx_valid` stays low in the same way.
- R6: A source that is not active drives its valid flag low and its bid word to all zeros.
- R7: With the other fields held, the receiver bid word increases strictly as `rx_count` rises through the active range.
- R8: The receiver and transmitter bids are formed independently. Changing one direction's inputs leaves the other direction's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_count | input | 5 | Entries held in the receive FIFO (0..16) |
| tx_space | input | 5 | Free slots in the transmit FIFO (0..16) |
| rx_level | input | 2 | Receiver start-level code |
| tx_level | input | 2 | Transmitter start-level code |
| rx_en | input | 1 | Receiver interrupt enable |
| tx_en | input | 1 | Transmitter interrupt enable |
| chan | input | 2 | Channel number placed in the bid |
| prio | input | 2 | Programmable priority field |
| rx_valid | output | 1 | Receiver is bidding |
| rx_bid | output | 10 | Receiver bid word |
| tx_valid | output | 1 | Transmitter is bidding |
| tx_bid | output | 10 | Transmitter bid word |

## Verification
Every result is due in the same cycle as its stimulus, because no register sits between the inputs and the outputs. The driver changes the inputs on a falling clock edge and queues the expected words at the same moment. The monitor pops the queue and compares on the following rising edge, half a period later, when the outputs have long settled. Each queued item therefore lines up with exactly one applied input set, and nothing is sampled while the inputs are moving.

// File: rtl/fifo_irq_bid.sv
module fifo_irq_bid #(
  parameter int DEPTH = 16,
  parameter int PRI_W = 2,
  parameter int CH_W  = 2,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int BID_W = CNT_W + PRI_W + CH_W + 1
) (
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_space,
  input  logic [1:0]       rx_level,
  input  logic [1:0]       tx_level,
  input  logic             rx_en,
  input  logic             tx_en,
  input  logic [CH_W-1:0]  chan,
  input  logic [PRI_W-1:0] prio,
  output logic             rx_valid,
  output logic [BID_W-1:0] rx_bid,
  output logic             tx_valid,
  output logic [BID_W-1:0] tx_bid
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TQTR = CNT_W'((3 * DEPTH) / 4);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  function automatic logic crossed(input logic [CNT_W-1:0] n, input logic [1:0] lvl);
    case (lvl)
      2'd0:    crossed = n >= ONE;
      2'd1:    crossed = n >= HALF;
      2'd2:    crossed = n >= TQTR;
      default: crossed = n >= FULL;
    endcase
  endfunction

  assign rx_valid = rx_en && crossed(rx_count, rx_level);
  assign tx_valid = tx_en && crossed(tx_space, tx_level);

  assign rx_bid = rx_valid ? {rx_count, prio, chan, 1'b1} : '0;
  assign tx_bid = tx_valid ? {tx_space, prio, chan, 1'b0} : '0;

  always_comb begin
    assert_rx_tag_R1: assert (!rx_valid || rx_bid[0]);
    assert_tx_tag_R2: assert (!tx_valid || !tx_bid[0]);
    assert_rx_nonempty_R3: assert (!rx_valid || rx_count != '0);
    assert_tx_nonfull_R4: assert (!tx_valid || tx_space != '0);
    assert_mask_gates_R5: assert ((rx_en || !rx_valid) && (tx_en || !tx_valid));
    assert_idle_zero_R6: assert ((rx_valid || rx_bid == '0) && (tx_valid || tx_bid == '0));
  end

endmodule

// File: tb/fifo_irq_bid_bench.sv
module fifo_irq_bid_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0] rx_count, tx_space;
  logic [1:0] rx_level, tx_level, chan, prio;
  logic       rx_en, tx_en;
  logic       rx_valid, tx_valid;
  logic [9:0] rx_bid, tx_bid;

  fifo_irq_bid u_fifo_irq_bid (
    .rx_count(rx_count), .tx_space(tx_space), .rx_level(rx_level), .tx_level(tx_level),
    .rx_en(rx_en), .tx_en(tx_en), .chan(chan), .prio(prio),
    .rx_valid(rx_valid), .rx_bid(rx_bid), .tx_valid(tx_valid), .tx_bid(tx_bid)
  );

  typedef struct {
    logic       rv;
    logic [9:0] rb;
    logic       tv;
    logic [9:0] tb;
    string      tag;
  } exp_t;

  exp_t q[$];
  int tests = 0;
  int fails = 0;
  logic [9:0] prev_r7 = '0;

  function automatic int start_of(input logic [1:0] lvl);
    case (lvl)
      2'd0: return 1;
      2'd1: return 8;
      2'd2: return 12;
      default: return 16;
    endcase
  endfunction

  task automatic apply(input int rc, input int ts, input int rl, input int tl,
                       input bit re, input bit te, input int ch, input int pr, input string tag);
    exp_t e;
    @(negedge clk);
    rx_count = 5'(rc); tx_space = 5'(ts);
    rx_level = 2'(rl); tx_level = 2'(tl);
    rx_en = re; tx_en = te; chan = 2'(ch); prio = 2'(pr);
    e.rv = re && (rc >= start_of(2'(rl)));
    e.tv = te && (ts >= start_of(2'(tl)));
    e.rb = e.rv ? 10'((rc << 5) | (pr << 3) | (ch << 1) | 1) : 10'd0;
    e.tb = e.tv ? 10'((ts << 5) | (pr << 3) | (ch << 1)) : 10'd0;
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      tests++;
      if (rx_valid !== e.rv || rx_bid !== e.rb || tx_valid !== e.tv || tx_bid !== e.tb) begin
        fails++;
        $display("FAIL %s: got rxv=%b rxb=%h txv=%b txb=%h, expected rxv=%b rxb=%h txv=%b txb=%h",
                 e.tag, rx_valid, rx_bid, tx_valid, tx_bid, e.rv, e.rb, e.tv, e.tb);
      end
      if (e.tag == "R7") begin
        tests++;
        if (!(rx_bid > prev_r7)) begin
          fails++;
          $display("FAIL R7: got rx_bid=%h not above previous %h, expected strictly larger",
                   rx_bid, prev_r7);
        end
        prev_r7 = rx_bid;
      end
    end
  end

  initial begin
    rx_count = '0; tx_space = '0; rx_level = '0; tx_level = '0;
    rx_en = 1'b0; tx_en = 1'b0; chan = '0; prio = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply(0, 0, 0, 0, 0, 0, 0, 0, "R6");
    // R1, R3: receiver thresholds across every level and count
    for (int l = 0; l < 4; l++)
      for (int c = 0; c <= 16; c++)
        apply(c, 0, l, 0, 1, 1, l, 3 - l, "R3");
    // R2, R4: transmitter thresholds
    for (int l = 0; l < 4; l++)
      for (int c = 0; c <= 16; c++)
        apply(0, c, 0, l, 1, 1, 3 - l, l, "R4");
    // R5: masks off with full levels
    apply(16, 16, 0, 0, 0, 0, 2, 1, "R5");
    apply(16, 16, 3, 3, 0, 1, 1, 2, "R5");
    apply(16, 16, 3, 3, 1, 0, 3, 3, "R5");
    // R1, R2: field placement with varied channel and priority
    for (int ch = 0; ch < 4; ch++)
      for (int pr = 0; pr < 4; pr++) begin
        apply(5 + ch, 9 + pr, 0, 0, 1, 1, ch, pr, "R1");
        apply(3, 16 - ch, 0, 0, 1, 1, ch, pr, "R2");
      end
    // R6: below threshold gives zero
    apply(11, 7, 2, 1, 1, 1, 3, 3, "R6");
    // R7: monotonic receiver bid
    prev_r7 = '0;
    for (int c = 1; c <= 16; c++) apply(c, 0, 0, 0, 1, 0, 1, 1, "R7");
    // R8: one direction moves while the other is held
    for (int c = 0; c <= 16; c += 4) apply(10, c, 1, 0, 1, 1, 2, 2, "R8");
    for (int c = 0; c <= 16; c += 4) apply(c, 13, 0, 2, 1, 1, 2, 2, "R8");
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule